// File: doc/BRIEF.md
# Accumulator-to-Halfword Extraction Unit

This block turns a 40-bit accumulator value into a 16-bit halfword for a register file. Three conversions are offered. The unsigned-fraction conversion drops the low sixteen bits without rounding. The signed-fraction conversion doubles the value and then rounds it to sixteen bits. The signed-integer conversion doubles the low sixteen bits of the accumulator. Each conversion ends by clamping the result to its 16-bit range. A flag reports whenever the clamp changed the value.

The sender presents the accumulator, a 2-bit conversion select and a rounding-style bit together with a valid strobe. One clock later the result appears with its own valid strobe and the clamp flag. All three conversions are computed side by side and a select picks one of them. Every overflow decision is taken on the value after doubling and rounding, which is kept at full width until the clamp, so no bits are discarded before it.

Top module: `acc_halfword_extract`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. A synchronous reset drives `out_valid`, `half_out` and `sat_out` to 0.
- R2: With `mode_sel` = 0 (unsigned fraction) and `acc_in[39:32]` all zero, `half_out` is `acc_in[31:16]`. The low sixteen bits never round, whatever `rnd_biased` holds, and `sat_out` stays 0.
- R3: With `mode_sel` = 0 and any bit of `acc_in[39:32]` set, `half_out` is 0xFFFF and `sat_out` is 1.
- R4: With `mode_sel` = 1 (signed fraction) and `rnd_biased` = 1, the result is the two's complement accumulator times two, divided by 2^16, rounded half-up (floor of x/2^15 + 1/2), whenever that fits in 16 signed bits.
- R5: With `mode_sel` = 1 and `rnd_biased` = 0, rounding is to nearest, and an exact half goes to the even result.
- R6: In signed-fraction mode the clamp acts on the rounded value. Results above 32767 give 0x7FFF and results below -32768 give 0x8000, each with `sat_out` = 1. Values that round into range are not flagged.
- R7: With `mode_sel` = 2 or 3 (signed integer), `half_out` is twice the signed value of `acc_in[15:0]`, and `acc_in[39:16]` is ignored. `sat_out` is 0 when that product fits in 16 signed bits.
- R8: In signed-integer mode a doubled value above 32767 gives 0x7FFF and one below -32768 gives 0x8000, with `sat_out` = 1.
- R9: `sat_out` is high only in a cycle where `out_valid` is high. `half_out` holds its value across cycles with no input strobe, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; the accumulator and controls are sampled when it is high |
| acc_in | input | 40 | Accumulator value |
| mode_sel | input | 2 | 0 unsigned fraction, 1 signed fraction, 2 or 3 signed integer |
| rnd_biased | input | 1 | Signed-fraction rounding: 1 rounds half up, 0 rounds half to even |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| half_out | output | 16 | Converted halfword |
| sat_out | output | 1 | The clamp altered this result |

## Verification
The properties treat `mode_sel`, `acc_in` and `rnd_biased` as meaningful only in cycles where `in_valid` is high. They make no claim about inputs in idle cycles, apart from requiring that the held result does not move. The stimulus changes the accumulator and the controls only at falling edges, together with the strobe. It also drives unrelated values during idle cycles so that the hold property is actually exercised. Every conversion select is reached, both signs appear, and the accumulator values sit exactly at the rounding ties and the clamp edges.

// File: rtl/xh_pkg.sv
package xh_pkg;

  typedef enum logic [1:0] {
    XH_UFRAC    = 2'd0,
    XH_SFRAC    = 2'd1,
    XH_SINT     = 2'd2,
    XH_SINT_ALT = 2'd3
  } xh_mode_e;

  localparam int XH_ACC_W = 40;
  localparam int XH_OUT_W = 16;

endpackage

// File: rtl/xh_rounder.sv
// Drops DROP low bits of a two's complement value, rounding to nearest.
// biased=1: half rounds up; biased=0: half rounds to the even result.
module xh_rounder #(
  parameter int IN_W = 41,
  parameter int DROP = 16
) (
  input  logic [IN_W-1:0]      din,
  input  logic                 biased,
  output logic [IN_W-DROP:0]   dout
);
  localparam int KEEP_W = IN_W - DROP;

  logic [KEEP_W-1:0] kept;
  logic              half_bit;
  logic              sticky;
  logic              inc;

  always_comb begin
    kept     = din[IN_W-1:DROP];
    half_bit = din[DROP-1];
    sticky   = |din[DROP-2:0];
    if (biased) inc = half_bit;
    else        inc = half_bit & (sticky | kept[0]);
    // one extra head bit so a carry out of the kept field is never lost
    dout = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, inc};
  end

endmodule

// File: rtl/xh_sat_signed.sv
// Clamps a wide two's complement value into OUT_W signed bits.
module xh_sat_signed #(
  parameter int IN_W  = 26,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             clipped
);
  localparam int HEAD_W = IN_W - OUT_W + 1;

  logic [HEAD_W-1:0] head;
  logic              fits;

  always_comb begin
    head = din[IN_W-1:OUT_W-1];
    fits = (&head) | ~(|head);
    if (fits) begin
      dout    = din[OUT_W-1:0];
      clipped = 1'b0;
    end else begin
      dout    = din[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
      clipped = 1'b1;
    end
  end

endmodule

// File: rtl/xh_sat_unsigned.sv
// Clamps a wide unsigned value into OUT_W bits.
module xh_sat_unsigned #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             clipped
);
  always_comb begin
    clipped = |din[IN_W-1:OUT_W];
    dout    = clipped ? {OUT_W{1'b1}} : din[OUT_W-1:0];
  end

endmodule

// File: rtl/acc_halfword_extract.sv
module acc_halfword_extract
  import xh_pkg::*;
#(
  parameter int ACC_W = XH_ACC_W,
  parameter int OUT_W = XH_OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [1:0]       mode_sel,
  input  logic             rnd_biased,
  output logic             out_valid,
  output logic [OUT_W-1:0] half_out,
  output logic             sat_out
);
  localparam int DBL_W   = ACC_W + 1;          // accumulator after doubling
  localparam int RND_W   = DBL_W - OUT_W + 1;  // rounded, with carry head
  localparam int UTRUNC_W = ACC_W - OUT_W;     // unsigned value after truncation
  localparam int SINT_W  = OUT_W + 1;          // doubled low half

  xh_mode_e mode;
  assign mode = xh_mode_e'(mode_sel);

  // unsigned fraction: truncate, then clamp
  logic [OUT_W-1:0] u_res;
  logic             u_clip;

  xh_sat_unsigned #(.IN_W(UTRUNC_W), .OUT_W(OUT_W)) i_usat (
    .din     (acc_in[ACC_W-1:OUT_W]),
    .dout    (u_res),
    .clipped (u_clip)
  );

  // signed fraction: double, round at full width, then clamp
  logic [DBL_W-1:0] f_dbl;
  logic [RND_W-1:0] f_rnd;
  logic [OUT_W-1:0] f_res;
  logic             f_clip;

  assign f_dbl = {acc_in, 1'b0};

  xh_rounder #(.IN_W(DBL_W), .DROP(OUT_W)) i_rnd (
    .din    (f_dbl),
    .biased (rnd_biased),
    .dout   (f_rnd)
  );

  xh_sat_signed #(.IN_W(RND_W), .OUT_W(OUT_W)) i_fsat (
    .din     (f_rnd),
    .dout    (f_res),
    .clipped (f_clip)
  );

  // signed integer: double the low half, then clamp
  logic [SINT_W-1:0] i_dbl;
  logic [OUT_W-1:0]  i_res;
  logic              i_clip;

  assign i_dbl = {acc_in[OUT_W-1:0], 1'b0};

  xh_sat_signed #(.IN_W(SINT_W), .OUT_W(OUT_W)) i_isat (
    .din     (i_dbl),
    .dout    (i_res),
    .clipped (i_clip)
  );

  // select the conversion
  logic [OUT_W-1:0] sel_res;
  logic             sel_clip;

  always_comb begin
    unique case (mode)
      XH_UFRAC: begin
        sel_res  = u_res;
        sel_clip = u_clip;
      end
      XH_SFRAC: begin
        sel_res  = f_res;
        sel_clip = f_clip;
      end
      default: begin
        sel_res  = i_res;
        sel_clip = i_clip;
      end
    endcase
  end

  // output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      half_out  <= '0;
      sat_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      sat_out   <= in_valid & sel_clip;
      if (in_valid) half_out <= sel_res;
    end
  end

endmodule

// File: rtl/xh_checker.sv
module xh_checker
  import xh_pkg::*;
#(
  parameter int ACC_W = XH_ACC_W,
  parameter int OUT_W = XH_OUT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [ACC_W-1:0] acc_in,
  input logic [1:0]       mode_sel,
  input logic             out_valid,
  input logic [OUT_W-1:0] half_out,
  input logic             sat_out
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic u_over;
  logic f_exact_fit;
  logic i_fit;

  assign u_over      = |acc_in[ACC_W-1:2*OUT_W];
  assign f_exact_fit = (acc_in[OUT_W-2:0] == '0) &&
                       ((&acc_in[ACC_W-1:2*OUT_W-2]) || !(|acc_in[ACC_W-1:2*OUT_W-2]));
  assign i_fit       = acc_in[OUT_W-1] == acc_in[OUT_W-2];

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_ufrac_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == XH_UFRAC && !u_over)
      |=> (!sat_out && half_out == $past(acc_in[2*OUT_W-1:OUT_W])));

  assert_ufrac_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == XH_UFRAC && u_over)
      |=> (sat_out && half_out == {OUT_W{1'b1}}));

  assert_sfrac_exact_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == XH_SFRAC && f_exact_fit)
      |=> (!sat_out && half_out == $past(acc_in[2*OUT_W-2:OUT_W-1])));

  assert_sfrac_clamp_value_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel == XH_SFRAC)
      |=> (!sat_out || half_out == POS_MAX || half_out == NEG_MIN));

  assert_sint_fit_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel[1] && i_fit) |=> !sat_out);

  assert_sint_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_sel[1] && !i_fit)
      |=> (sat_out && half_out == (acc_in[OUT_W-1] ? NEG_MIN : POS_MAX)) or
          (sat_out && half_out == ($past(acc_in[OUT_W-1]) ? NEG_MIN : POS_MAX)));

  assert_flag_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    sat_out |-> out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(half_out));

endmodule

bind acc_halfword_extract xh_checker #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .acc_in    (acc_in),
  .mode_sel  (mode_sel),
  .out_valid (out_valid),
  .half_out  (half_out),
  .sat_out   (sat_out)
);

// File: tb/test_acc_halfword_extract.sv
`timescale 1ns/1ps
module test_acc_halfword_extract;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [39:0] acc_in;
  logic [1:0]  mode_sel;
  logic        rnd_biased;
  logic        out_valid;
  logic [15:0] half_out;
  logic        sat_out;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  acc_halfword_extract i_acc_halfword_extract (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .acc_in     (acc_in),
    .mode_sel   (mode_sel),
    .rnd_biased (rnd_biased),
    .out_valid  (out_valid),
    .half_out   (half_out),
    .sat_out    (sat_out)
  );

  // {req[4], mode[2], rnd[1], acc[40], expected half[16], expected flag[1]}
  localparam int NV = 31;
  localparam logic [63:0] VEC [NV] = '{
    {4'd2, 2'd0, 1'b0, 40'h00_1234_5678, 16'h1234, 1'b0}, // R2
    {4'd2, 2'd0, 1'b0, 40'h00_FFFF_FFFF, 16'hFFFF, 1'b0}, // R2 top of range, not clamped
    {4'd2, 2'd0, 1'b1, 40'h00_ABCD_8000, 16'hABCD, 1'b0}, // R2 no rounding
    {4'd3, 2'd0, 1'b0, 40'h01_0000_0000, 16'hFFFF, 1'b1}, // R3
    {4'd3, 2'd0, 1'b1, 40'hFF_0000_0000, 16'hFFFF, 1'b1}, // R3
    {4'd4, 2'd1, 1'b1, 40'h00_1234_0000, 16'h2468, 1'b0}, // R4
    {4'd4, 2'd1, 1'b1, 40'h00_0000_4000, 16'h0001, 1'b0}, // R4 tie up
    {4'd4, 2'd1, 1'b1, 40'h00_0000_2000, 16'h0000, 1'b0}, // R4 below half
    {4'd4, 2'd1, 1'b1, 40'hFF_FFFF_4000, 16'hFFFF, 1'b0}, // R4 -1.5 -> -1
    {4'd5, 2'd1, 1'b0, 40'h00_0000_4000, 16'h0000, 1'b0}, // R5 tie to even 0
    {4'd5, 2'd1, 1'b0, 40'h00_0000_C000, 16'h0002, 1'b0}, // R5 tie 1.5 -> 2
    {4'd5, 2'd1, 1'b0, 40'h00_0000_6000, 16'h0001, 1'b0}, // R5 above half
    {4'd5, 2'd1, 1'b0, 40'hFF_FFFF_4000, 16'hFFFE, 1'b0}, // R5 -1.5 -> -2
    {4'd5, 2'd1, 1'b0, 40'h00_3FFF_A000, 16'h7FFF, 1'b0}, // R5 below half at top
    {4'd6, 2'd1, 1'b1, 40'h00_3FFF_C000, 16'h7FFF, 1'b1}, // R6 rounds over top
    {4'd6, 2'd1, 1'b0, 40'h00_3FFF_C000, 16'h7FFF, 1'b1}, // R6 odd tie over top
    {4'd6, 2'd1, 1'b1, 40'h00_4000_0000, 16'h7FFF, 1'b1}, // R6
    {4'd6, 2'd1, 1'b0, 40'hFF_C000_0000, 16'h8000, 1'b0}, // R6 exact minimum
    {4'd6, 2'd1, 1'b1, 40'hFF_BFFF_8000, 16'h8000, 1'b1}, // R6 below minimum
    {4'd6, 2'd1, 1'b1, 40'h7F_FFFF_FFFF, 16'h7FFF, 1'b1}, // R6 largest
    {4'd6, 2'd1, 1'b0, 40'h80_0000_0000, 16'h8000, 1'b1}, // R6 smallest
    {4'd6, 2'd1, 1'b1, 40'hFF_BFFF_C000, 16'h8000, 1'b0}, // R6 rounds into range
    {4'd6, 2'd1, 1'b0, 40'hFF_BFFF_C000, 16'h8000, 1'b0}, // R6 even tie into range
    {4'd7, 2'd2, 1'b0, 40'h00_0000_1234, 16'h2468, 1'b0}, // R7
    {4'd7, 2'd2, 1'b1, 40'h7F_FFFF_1234, 16'h2468, 1'b0}, // R7 upper bits ignored
    {4'd7, 2'd2, 1'b0, 40'h00_0000_3FFF, 16'h7FFE, 1'b0}, // R7
    {4'd7, 2'd2, 1'b0, 40'h00_0000_C000, 16'h8000, 1'b0}, // R7 exact minimum
    {4'd7, 2'd3, 1'b0, 40'h00_0000_FFFF, 16'hFFFE, 1'b0}, // R7 select 3
    {4'd8, 2'd2, 1'b0, 40'h00_0000_4000, 16'h7FFF, 1'b1}, // R8
    {4'd8, 2'd2, 1'b0, 40'h00_0000_BFFF, 16'h8000, 1'b1}, // R8
    {4'd8, 2'd3, 1'b1, 40'hAA_5555_8000, 16'h8000, 1'b1}  // R8 select 3
  };

  task automatic check(input int req, input logic [15:0] got_h, input logic [15:0] exp_h,
                       input logic got_s, input logic exp_s, input logic got_v, input logic exp_v);
    checks++;
    if (got_h !== exp_h || got_s !== exp_s || got_v !== exp_v) begin
      errors++;
      $display("FAIL R%0d: half=%h sat=%b valid=%b, expected half=%h sat=%b valid=%b",
               req, got_h, got_s, got_v, exp_h, exp_s, exp_v);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m, input logic r, input logic [39:0] a);
    @(negedge clk);
    in_valid   = v;
    mode_sel   = m;
    rnd_biased = r;
    acc_in     = a;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; mode_sel = 2'd0; rnd_biased = 1'b0; acc_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, half_out, 16'h0000, sat_out, 1'b0, out_valid, 1'b0);
    rst = 1'b0;

    // vector table: one strobe, sample one clock later
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][59:58], VEC[i][57], VEC[i][56:17]);
      drive(1'b0, 2'd0, 1'b0, 40'h0);
      check(int'(VEC[i][63:60]), half_out, VEC[i][16:1], sat_out, VEC[i][0], out_valid, 1'b1);
    end

    // R9: idle cycles with changing inputs leave the clamped result in place
    drive(1'b1, 2'd0, 1'b0, 40'h05_0000_0000);
    drive(1'b0, 2'd1, 1'b1, 40'h00_1234_0000);
    check(3, half_out, 16'hFFFF, sat_out, 1'b1, out_valid, 1'b1);
    drive(1'b0, 2'd2, 1'b0, 40'h00_0000_4000);
    check(9, half_out, 16'hFFFF, sat_out, 1'b0, out_valid, 1'b0);
    drive(1'b0, 2'd0, 1'b1, 40'h00_0000_0000);
    check(9, half_out, 16'hFFFF, sat_out, 1'b0, out_valid, 1'b0);

    // R1: back-to-back strobes, one result per clock
    drive(1'b1, 2'd2, 1'b0, 40'h00_0000_0100);
    drive(1'b1, 2'd1, 1'b0, 40'h00_0000_C000);
    check(7, half_out, 16'h0200, sat_out, 1'b0, out_valid, 1'b1);
    drive(1'b1, 2'd2, 1'b0, 40'h00_0000_7000);
    check(5, half_out, 16'h0002, sat_out, 1'b0, out_valid, 1'b1);
    drive(1'b0, 2'd0, 1'b0, 40'h0);
    check(8, half_out, 16'h7FFF, sat_out, 1'b1, out_valid, 1'b1);
    drive(1'b0, 2'd0, 1'b0, 40'h0);
    check(1, half_out, 16'h7FFF, sat_out, 1'b0, out_valid, 1'b0);

    // R1: reset wins over a strobe in the same cycle
    drive(1'b1, 2'd0, 1'b0, 40'h01_0000_0000);
    rst = 1'b1;
    drive(1'b0, 2'd0, 1'b0, 40'h0);
    rst = 1'b0;
    check(1, half_out, 16'h0000, sat_out, 1'b0, out_valid, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule